// File: doc/BRIEF.md
# RTC interrupt and frequency output controller

This block drives the single shared output pin of a real-time clock. The pin is open-drain and active-low, and it serves two purposes. It can carry a square wave derived from the 32.768 kHz timebase, at one of fifteen rates from 32768 Hz down to 1/32 Hz. It can also signal an alarm. The pin is modelled as an output-enable: while `pin_oe` is high the pin is pulled low, and while it is low an external pull-up holds the pin high.

An alarm-match strobe from the time comparator sets a sticky alarm flag. The flag is visible to software, which drops it through a clear request. In level mode the pin is held low for as long as the flag stays set. In pulse mode each match produces one low pulse of a fixed 250 ms instead. A nonzero rate select always takes the pin away from the alarm logic. During battery backup, a mute control can release the pin completely.

Top module: `rtc_pin_ctrl`

## Requirements
- R1: When the active rate select is 0, no square wave is produced and the pin carries only the alarm signalling.
- R2: With rate select 1, the pin follows the 32.768 kHz input directly: `pin_oe` is high while `clk_32k` is low and low while it is high.
- R3: Select codes 2 to 15 give 50% duty square waves with half-periods of 4, 16, 256, 512, 1024, 2048, 4096, 8192, 16384, 32768, 65536, 131072, 262144 and 524288 input cycles, in code order. These correspond to 4096, 1024, 64, 32, 16, 8, 4, 2, 1, 1/2, 1/4, 1/8, 1/16 and 1/32 Hz. Each waveform starts with a released half-period.
- R4: A change of the select value is taken at the next clock edge, and that edge restarts the divider from zero. The first released half-period at the new rate is therefore complete.
- R5: While the active select is nonzero, the alarm flag and the pulse have no effect on the pin.
- R6: A match sets `alarm_flag` at the next edge. A clear request without a match drops it at the next edge. When both arrive in the same cycle, the flag is set.
- R7: In level mode (`pulse_mode`=0) with select 0, `pin_oe` equals `alarm_flag`.
- R8: In pulse mode with select 0, `pin_oe` is high for exactly PULSE_CYC cycles (8192 = 250 ms), beginning at the edge that captures the match. This happens whatever the flag holds.
- R9: A match that arrives during a pulse reloads the pulse to a full PULSE_CYC cycles.
- R10: When `bat_mute` and `on_battery` are both 1, `pin_oe` is 0 whatever the select and the alarm state. If either of them is 0, the pin works normally.
- R11: Reset clears the flag, idles the pulse, zeroes the divider and sets the active select to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_32k | input | 1 | 32.768 kHz timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 4 | Output rate select, 0 = off |
| pulse_mode | input | 1 | 1 = fixed pulse per match, 0 = level until cleared |
| bat_mute | input | 1 | Release the pin while on battery |
| on_battery | input | 1 | Battery backup is active |
| match_stb | input | 1 | Alarm match, one cycle |
| flag_clr | input | 1 | Software request to clear the alarm flag |
| pin_oe | output | 1 | 1 = pull the pin low |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The bench builds the block with its default parameters: a 20-bit divider and an 8192-cycle pulse. This means the true 250 ms pulse is measured edge by edge, including its first cycle, its last cycle and its restart. Full waveform periods are checked for the select codes up to 16384 cycles per half-period. The slowest code is only checked for its released first half, because a full period lies beyond the run length.

// File: rtl/rtc_pin_pkg.sv
package rtc_pin_pkg;

  localparam int SEL_W = 4;

  // Divider bit whose toggling yields the rate of a select code (codes 2..15).
  function automatic int tap_of(input logic [SEL_W-1:0] code);
    int t;
    case (code)
      4'd2:    t = 2;
      4'd3:    t = 4;
      default: t = (code >= 4'd4) ? int'(code) + 4 : 0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rtc_fout_div.sv
module rtc_fout_div #(
  parameter int DIV_W = 20
) (
  input  logic                          clk_32k,
  input  logic                          rst_n,
  input  logic [rtc_pin_pkg::SEL_W-1:0] freq_sel,
  output logic [rtc_pin_pkg::SEL_W-1:0] sel_q,
  output logic [DIV_W-1:0]              div_cnt
);
  import rtc_pin_pkg::*;

  logic [SEL_W-1:0] sel_nx;
  logic [DIV_W-1:0] cnt_nx;
  logic             sel_chg;

  assign sel_chg = (freq_sel != sel_q);

  always_comb begin
    sel_nx = sel_q;
    cnt_nx = div_cnt + 1'b1;
    if (sel_chg) begin
      sel_nx = freq_sel;
      cnt_nx = '0;
    end
  end

  always_ff @(posedge clk_32k or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_W'(1);
      div_cnt <= '0;
    end else begin
      sel_q   <= sel_nx;
      div_cnt <= cnt_nx;
    end
  end

endmodule

// File: rtl/rtc_fout_pick.sv
module rtc_fout_pick #(
  parameter int DIV_W = 20
) (
  input  logic                          clk_32k,
  input  logic [rtc_pin_pkg::SEL_W-1:0] sel_q,
  input  logic [DIV_W-1:0]              div_cnt,
  output logic                          fout_oe
);
  import rtc_pin_pkg::*;

  localparam int TAP_W = (DIV_W > 1) ? $clog2(DIV_W) : 1;

  logic [TAP_W-1:0] tap_idx;
  int               tap;

  always_comb begin
    tap = tap_of(sel_q);
    if (tap > DIV_W - 1) tap = DIV_W - 1;
    tap_idx = TAP_W'(tap);
    if (sel_q == SEL_W'(1)) fout_oe = ~clk_32k;
    else                    fout_oe = div_cnt[tap_idx];
  end

endmodule

// File: rtl/rtc_alarm_sig.sv
module rtc_alarm_sig #(
  parameter int PULSE_CYC = 8192,
  parameter int PCNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic              clk_32k,
  input  logic              rst_n,
  input  logic              pulse_mode,
  input  logic              match_stb,
  input  logic              flag_clr,
  output logic              alarm_flag,
  output logic [PCNT_W-1:0] pulse_cnt
);

  logic              flag_nx;
  logic [PCNT_W-1:0] pcnt_nx;
  logic              pcnt_en;

  always_comb begin
    flag_nx = alarm_flag;
    if (match_stb)     flag_nx = 1'b1;
    else if (flag_clr) flag_nx = 1'b0;
  end

  assign pcnt_en = (match_stb && pulse_mode) || (pulse_cnt != '0);

  always_comb begin
    if (match_stb && pulse_mode) pcnt_nx = PCNT_W'(PULSE_CYC);
    else                         pcnt_nx = pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk_32k or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      pulse_cnt  <= '0;
    end else begin
      alarm_flag <= flag_nx;
      if (pcnt_en) pulse_cnt <= pcnt_nx;
    end
  end

endmodule

// File: rtl/rtc_pin_ctrl.sv
module rtc_pin_ctrl #(
  parameter int DIV_W     = 20,
  parameter int PULSE_CYC = 8192
) (
  input  logic       clk_32k,
  input  logic       rst_n,
  input  logic [3:0] freq_sel,
  input  logic       pulse_mode,
  input  logic       bat_mute,
  input  logic       on_battery,
  input  logic       match_stb,
  input  logic       flag_clr,
  output logic       pin_oe,
  output logic       alarm_flag
);
  import rtc_pin_pkg::*;

  localparam int PCNT_W = $clog2(PULSE_CYC + 1);

  logic [SEL_W-1:0]  act_sel;
  logic [DIV_W-1:0]  div_cnt;
  logic [PCNT_W-1:0] pulse_cnt;
  logic              fout_oe;
  logic              alarm_oe;
  logic              muted;

  rtc_fout_div #(.DIV_W(DIV_W)) u_div (
    .clk_32k (clk_32k),
    .rst_n   (rst_n),
    .freq_sel(freq_sel),
    .sel_q   (act_sel),
    .div_cnt (div_cnt)
  );

  rtc_fout_pick #(.DIV_W(DIV_W)) u_pick (
    .clk_32k(clk_32k),
    .sel_q  (act_sel),
    .div_cnt(div_cnt),
    .fout_oe(fout_oe)
  );

  rtc_alarm_sig #(.PULSE_CYC(PULSE_CYC), .PCNT_W(PCNT_W)) u_alm (
    .clk_32k   (clk_32k),
    .rst_n     (rst_n),
    .pulse_mode(pulse_mode),
    .match_stb (match_stb),
    .flag_clr  (flag_clr),
    .alarm_flag(alarm_flag),
    .pulse_cnt (pulse_cnt)
  );

  assign alarm_oe = pulse_mode ? (pulse_cnt != '0) : alarm_flag;
  assign muted    = bat_mute & on_battery;

  always_comb begin
    if (muted)                pin_oe = 1'b0;
    else if (act_sel != '0)   pin_oe = fout_oe;
    else                      pin_oe = alarm_oe;
  end

endmodule

// File: rtl/rtc_pin_ctrl_chk.sv
module rtc_pin_ctrl_chk #(
  parameter int DIV_W     = 20,
  parameter int PULSE_CYC = 8192,
  parameter int PCNT_W    = $clog2(PULSE_CYC + 1)
) (
  input logic              clk_32k,
  input logic              rst_n,
  input logic [3:0]        freq_sel,
  input logic              pulse_mode,
  input logic              bat_mute,
  input logic              on_battery,
  input logic              match_stb,
  input logic              flag_clr,
  input logic              pin_oe,
  input logic              alarm_flag,
  input logic [3:0]        act_sel,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [PCNT_W-1:0] pulse_cnt
);

  a_r6_match_sets_flag: assert property (@(posedge clk_32k) disable iff (!rst_n)
    match_stb |=> alarm_flag);

  a_r6_clear_drops_flag: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (flag_clr && !match_stb) |=> !alarm_flag);

  a_r10_mute_releases: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (bat_mute && on_battery) |-> !pin_oe);

  a_r4_restart_zero: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (freq_sel != act_sel) |=> (div_cnt == '0 && act_sel == $past(freq_sel)));

  a_r8_pulse_load: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (match_stb && pulse_mode) |=> (pulse_cnt == PCNT_W'(PULSE_CYC)));

  a_r9_pulse_bound: assert property (@(posedge clk_32k) disable iff (!rst_n)
    pulse_cnt <= PCNT_W'(PULSE_CYC));

  a_r7_level_follow: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (act_sel == 4'd0 && !pulse_mode && !(bat_mute && on_battery)) |-> (pin_oe == alarm_flag));

endmodule

bind rtc_pin_ctrl rtc_pin_ctrl_chk #(.DIV_W(DIV_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_32k   (clk_32k),
  .rst_n     (rst_n),
  .freq_sel  (freq_sel),
  .pulse_mode(pulse_mode),
  .bat_mute  (bat_mute),
  .on_battery(on_battery),
  .match_stb (match_stb),
  .flag_clr  (flag_clr),
  .pin_oe    (pin_oe),
  .alarm_flag(alarm_flag),
  .act_sel   (act_sel),
  .div_cnt   (div_cnt),
  .pulse_cnt (pulse_cnt)
);

// File: tb/rtc_pin_ctrl_tb.sv
module rtc_pin_ctrl_tb;

  localparam int CLK_PERIOD = 40;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int PULSE      = 8192;

  logic       clk_32k = 1'b0;
  logic       rst_n;
  logic [3:0] freq_sel;
  logic       pulse_mode, bat_mute, on_battery, match_stb, flag_clr;
  logic       pin_oe, alarm_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_32k = ~clk_32k;

  rtc_pin_ctrl u_dut (
    .clk_32k(clk_32k), .rst_n(rst_n), .freq_sel(freq_sel),
    .pulse_mode(pulse_mode), .bat_mute(bat_mute), .on_battery(on_battery),
    .match_stb(match_stb), .flag_clr(flag_clr),
    .pin_oe(pin_oe), .alarm_flag(alarm_flag)
  );

  // Advance n rising edges; return in the middle of the low phase.
  task automatic step(input int n);
    repeat (n) @(negedge clk_32k);
    #(QTR);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int half_of(input logic [3:0] code);
    case (code)
      4'd2: return 4;      4'd3: return 16;     4'd4: return 256;
      4'd5: return 512;    4'd9: return 8192;   4'd10: return 16384;
      4'd15: return 524288;
      default: return 1;
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; freq_sel = 4'd1; pulse_mode = 1'b0; bat_mute = 1'b0;
    on_battery = 1'b0; match_stb = 1'b0; flag_clr = 1'b0;
    step(3);
    chk("R11 flag in reset", alarm_flag, 1'b0);
    chk("R11 select resets to 1, low phase", pin_oe, 1'b1);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_pass;
    for (int i = 0; i < 3; i++) begin
      chk("R2 clock low -> oe high", pin_oe, 1'b1);
      @(posedge clk_32k); #(QTR);
      chk("R2 clock high -> oe low", pin_oe, 1'b0);
      step(1);
    end
  endtask

  task automatic t_freq(input logic [3:0] code);
    int h = half_of(code);
    int pts[5] = '{0, h - 1, h, 2*h - 1, 2*h};
    int k = 0;
    freq_sel = code;
    step(1);                          // edge that restarts the divider
    foreach (pts[i]) begin
      step(pts[i] - k);
      k = pts[i];
      chk($sformatf("R3 R4 code %0d cycle %0d", code, k), pin_oe, logic'((k / h) % 2));
    end
  endtask

  task automatic t_slowest;
    freq_sel = 4'd15;
    step(1);
    chk("R4 code 15 start released", pin_oe, 1'b0);
    step(3000);
    chk("R3 code 15 still in first half", pin_oe, 1'b0);
  endtask

  task automatic t_priority;
    freq_sel = 4'd2; pulse_mode = 1'b0;
    step(1);
    match_stb = 1'b1;
    step(1);
    match_stb = 1'b0;
    chk("R5 flag set under freq", alarm_flag, 1'b1);
    chk("R5 square wins over flag", pin_oe, 1'b0);
    freq_sel = 4'd0;
    step(1);
    chk("R1 select 0 shows alarm", pin_oe, 1'b1);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    chk("R6 clear drops flag", alarm_flag, 1'b0);
    chk("R7 pin follows cleared flag", pin_oe, 1'b0);
  endtask

  task automatic t_level;
    match_stb = 1'b1;
    step(1);
    match_stb = 1'b0;
    chk("R6 match sets flag", alarm_flag, 1'b1);
    chk("R7 level asserted", pin_oe, 1'b1);
    step(20000 / 1000);
    chk("R7 level held", pin_oe, 1'b1);
    match_stb = 1'b1; flag_clr = 1'b1;
    step(1);
    match_stb = 1'b0;
    chk("R6 match beats clear", alarm_flag, 1'b1);
    step(1);
    flag_clr = 1'b0;
    chk("R6 clear alone", alarm_flag, 1'b0);
    chk("R7 released", pin_oe, 1'b0);
  endtask

  task automatic t_pulse;
    pulse_mode = 1'b1;
    match_stb = 1'b1;
    step(1);
    match_stb = 1'b0;
    chk("R8 pulse first cycle", pin_oe, 1'b1);
    chk("R6 flag set in pulse mode", alarm_flag, 1'b1);
    step(PULSE - 1);
    chk("R8 pulse last cycle", pin_oe, 1'b1);
    step(1);
    chk("R8 pulse ended though flag set", pin_oe, 1'b0);
    chk("R8 flag still set", alarm_flag, 1'b1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic t_retrigger;
    match_stb = 1'b1; step(1); match_stb = 1'b0;
    step(3999);
    match_stb = 1'b1; step(1); match_stb = 1'b0;
    step(PULSE - 1);
    chk("R9 reloaded pulse last cycle", pin_oe, 1'b1);
    step(1);
    chk("R9 reloaded pulse ended", pin_oe, 1'b0);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    pulse_mode = 1'b0;
  endtask

  task automatic t_battery;
    match_stb = 1'b1; step(1); match_stb = 1'b0;
    bat_mute = 1'b1; on_battery = 1'b1;
    step(1);
    chk("R10 muted alarm", pin_oe, 1'b0);
    freq_sel = 4'd1;
    step(1);
    chk("R10 muted clock low phase", pin_oe, 1'b0);
    @(posedge clk_32k); #(QTR);
    chk("R10 muted clock high phase", pin_oe, 1'b0);
    step(1);
    freq_sel = 4'd0;
    bat_mute = 1'b0;
    step(1);
    chk("R10 on battery, not muted", pin_oe, 1'b1);
    bat_mute = 1'b1; on_battery = 1'b0;
    step(1);
    chk("R10 muted, not on battery", pin_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_pass();
    freq_sel = 4'd0;
    step(1);
    chk("R11 no alarm after reset", pin_oe, 1'b0);
    chk("R1 select 0 idle", alarm_flag, 1'b0);
    t_freq(4'd2);
    t_freq(4'd3);
    t_freq(4'd4);
    t_freq(4'd5);
    t_freq(4'd9);
    t_freq(4'd10);
    t_slowest();
    t_priority();
    t_level();
    t_pulse();
    t_retrigger();
    t_battery();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule